// File: doc/BRIEF.md
# External-Port DMA Pacing Controller

This block decides, cycle by cycle, whether one external-port DMA channel raises an internal transfer request and whether a word crosses the external side. Three mode bits select the pacing rule: master, handshake and external. Enable, chaining and direction bits qualify that rule. The inputs are the channel buffer's empty and full flags, the remaining transfer count, an external request line, an external grant line, and the external read and write strobes.

The request, transfer strobe and single-word interrupt are registered, so each one reflects the inputs of the previous clock. Two status bits are also kept: channel active and chaining active. Each is first held in an internal state register and then copied to the output one cycle later. A status bit therefore reports its internal state with one cycle of delay. Address generation and the buffer storage sit in neighbouring blocks.

Top module: `xp_dma_pacer`

## Requirements
- R1: While reset is high, and in the first cycle after it, dma_req, xfer_stb, word_irq, stat_active and stat_chain are all 0.
- R2: Mode code {cfg_master,cfg_hshake,cfg_ext} = 000 (slave): dma_req follows the buffer need, and xfer_stb stays 0. Buffer need is "not empty" when cfg_tx=0 and "not full" when cfg_tx=1.
- R3: Mode 010 (handshake) with cfg_tx=0: dma_req follows ext_req. In either direction, xfer_stb follows ext_grant.
- R4: Mode 011 (external handshake) paces requests and strobes exactly as mode 010 does.
- R5: Mode 100 (master): dma_req and xfer_stb are both 1 exactly when xfer_cnt is nonzero and the buffer need holds.
- R6: Mode 110 (paced master): both outputs require a nonzero xfer_cnt. With cfg_tx=0, dma_req follows ext_req and xfer_stb follows rd_stb. With cfg_tx=1, xfer_stb follows wr_stb.
- R7: Mode codes 001, 101 and 111 never produce dma_req or xfer_stb.
- R8: With cfg_tx=1 in an enabled, non-reserved mode, dma_req rises whenever the buffer is not full (and, in modes 100 and 110, the count is nonzero), whatever the state of ext_req.
- R9: word_irq is cfg_irq_en AND buffer need, whatever cfg_en is: receive interrupts on partially full or full, transmit on partially full or empty.
- R10: With cfg_en=0, dma_req and xfer_stb stay 0.
- R11: The internal active state is cleared when cfg_en=0. With cfg_en=1 it is set while xfer_cnt is nonzero, cleared when the count is zero and the buffer is empty, and held otherwise.
- R12: The internal chaining state is cfg_en AND cfg_chain, so chain insertion (cfg_en=0, cfg_chain=1) never shows stat_chain=1.
- R13: dma_req, xfer_stb and word_irq change on the first clock edge after their inputs. stat_active and stat_chain change one edge after the internal state, which is two edges after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Channel enable |
| cfg_chain | input | 1 | Chaining enable |
| cfg_tx | input | 1 | Direction, 1 = transmit (internal to external) |
| cfg_master | input | 1 | Mode bit 2 |
| cfg_hshake | input | 1 | Mode bit 1 |
| cfg_ext | input | 1 | Mode bit 0 |
| cfg_irq_en | input | 1 | Single-word interrupt enable |
| buf_empty | input | 1 | Channel buffer is empty |
| buf_full | input | 1 | Channel buffer is full |
| xfer_cnt | input | CNT_W | Remaining transfer count |
| ext_req | input | 1 | External request line |
| ext_grant | input | 1 | External grant line |
| rd_stb | input | 1 | External read strobe |
| wr_stb | input | 1 | External write strobe |
| dma_req | output | 1 | Registered internal DMA request |
| xfer_stb | output | 1 | Registered external transfer strobe |
| word_irq | output | 1 | Registered single-word interrupt |
| stat_active | output | 1 | Channel-active status (delayed one cycle) |
| stat_chain | output | 1 | Chaining-active status (delayed one cycle) |

## Verification
The bench varies all inputs every cycle, so all three reserved codes are hit. A design that decoded a reserved code as its nearest legal neighbour would raise a request there.

Transmit with handshake pacing and ext_req low is targeted directly. A design that paced transmit fills by ext_req would leave dma_req low in that case.

A chain-insertion stretch checks stat_chain. A design that took chaining status from cfg_chain alone would report 1 there.

A directed latency check catches status taken straight from the internal state register. Such a design would show stat_active one cycle early, in the same cycle as the request.

// File: rtl/xp_pace_pkg.sv
package xp_pace_pkg;

  // {master, hshake, ext}
  typedef enum logic [2:0] {
    PM_SLAVE = 3'b000,
    PM_RSV1  = 3'b001,
    PM_HSHK  = 3'b010,
    PM_XHSHK = 3'b011,
    PM_MAST  = 3'b100,
    PM_RSV5  = 3'b101,
    PM_PACED = 3'b110,
    PM_RSV7  = 3'b111
  } pace_mode_e;

  typedef struct packed {
    logic req;
    logic stb;
    logic irq;
  } pace_evt_t;

endpackage

// File: rtl/pace_mode_dec.sv
module pace_mode_dec
  import xp_pace_pkg::*;
(
  input  logic       master_i,
  input  logic       hshake_i,
  input  logic       ext_i,
  output pace_mode_e mode_o,
  output logic       legal_o
);

  always_comb begin
    mode_o = pace_mode_e'({master_i, hshake_i, ext_i});
    unique case (mode_o)
      PM_SLAVE, PM_HSHK, PM_XHSHK, PM_MAST, PM_PACED: legal_o = 1'b1;
      default:                                       legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pace_req_gen.sv
module pace_req_gen
  import xp_pace_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tx_i,
  input  logic             irq_en_i,
  input  pace_mode_e       mode_i,
  input  logic             legal_i,
  input  logic             buf_empty_i,
  input  logic             buf_full_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ext_req_i,
  input  logic             ext_grant_i,
  input  logic             rd_stb_i,
  input  logic             wr_stb_i,
  output pace_evt_t        evt_o
);

  logic      need;
  logic      cnt_nz;
  logic      ext_pace;
  logic      strobe_dir;
  pace_evt_t evt_d;
  pace_evt_t evt_q;

  assign need       = tx_i ? ~buf_full_i : ~buf_empty_i;
  assign cnt_nz     = |cnt_i;
  assign ext_pace   = tx_i ? need : ext_req_i;
  assign strobe_dir = tx_i ? wr_stb_i : rd_stb_i;

  always_comb begin
    evt_d = '0;
    if (en_i && legal_i) begin
      unique case (mode_i)
        PM_SLAVE: evt_d.req = need;
        PM_HSHK, PM_XHSHK: begin
          evt_d.req = ext_pace;
          evt_d.stb = ext_grant_i;
        end
        PM_MAST: begin
          evt_d.req = cnt_nz & need;
          evt_d.stb = cnt_nz & need;
        end
        PM_PACED: begin
          evt_d.req = cnt_nz & ext_pace;
          evt_d.stb = cnt_nz & strobe_dir;
        end
        default: evt_d = '0;
      endcase
    end
    evt_d.irq = irq_en_i & need;
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_d;
  end

  assign evt_o = evt_q;

endmodule

// File: rtl/pace_status.sv
module pace_status (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic chain_i,
  input  logic cnt_nz_i,
  input  logic buf_empty_i,
  output logic act_o,
  output logic chn_o
);

  logic act_st, chn_st;
  logic act_q, chn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_st <= 1'b0;
      chn_st <= 1'b0;
    end else begin
      if (!en_i)            act_st <= 1'b0;
      else if (cnt_nz_i)    act_st <= 1'b1;
      else if (buf_empty_i) act_st <= 1'b0;
      chn_st <= en_i & chain_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      chn_q <= 1'b0;
    end else begin
      act_q <= act_st;
      chn_q <= chn_st;
    end
  end

  assign act_o = act_q;
  assign chn_o = chn_q;

endmodule

// File: rtl/xp_dma_pacer.sv
module xp_dma_pacer
  import xp_pace_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_chain,
  input  logic             cfg_tx,
  input  logic             cfg_master,
  input  logic             cfg_hshake,
  input  logic             cfg_ext,
  input  logic             cfg_irq_en,
  input  logic             buf_empty,
  input  logic             buf_full,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic             ext_req,
  input  logic             ext_grant,
  input  logic             rd_stb,
  input  logic             wr_stb,
  output logic             dma_req,
  output logic             xfer_stb,
  output logic             word_irq,
  output logic             stat_active,
  output logic             stat_chain
);

  pace_mode_e mode;
  logic       legal;
  pace_evt_t  evt;

  pace_mode_dec u_dec (
    .master_i (cfg_master),
    .hshake_i (cfg_hshake),
    .ext_i    (cfg_ext),
    .mode_o   (mode),
    .legal_o  (legal)
  );

  pace_req_gen #(.CNT_W(CNT_W)) u_req (
    .clk         (clk),
    .rst         (rst),
    .en_i        (cfg_en),
    .tx_i        (cfg_tx),
    .irq_en_i    (cfg_irq_en),
    .mode_i      (mode),
    .legal_i     (legal),
    .buf_empty_i (buf_empty),
    .buf_full_i  (buf_full),
    .cnt_i       (xfer_cnt),
    .ext_req_i   (ext_req),
    .ext_grant_i (ext_grant),
    .rd_stb_i    (rd_stb),
    .wr_stb_i    (wr_stb),
    .evt_o       (evt)
  );

  pace_status u_stat (
    .clk         (clk),
    .rst         (rst),
    .en_i        (cfg_en),
    .chain_i     (cfg_chain),
    .cnt_nz_i    (|xfer_cnt),
    .buf_empty_i (buf_empty),
    .act_o       (stat_active),
    .chn_o       (stat_chain)
  );

  assign dma_req  = evt.req;
  assign xfer_stb = evt.stb;
  assign word_irq = evt.irq;

endmodule

// File: rtl/pace_chk.sv
module pace_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_chain,
  input logic             cfg_tx,
  input logic             cfg_master,
  input logic             cfg_hshake,
  input logic             cfg_ext,
  input logic             cfg_irq_en,
  input logic             buf_empty,
  input logic             buf_full,
  input logic [CNT_W-1:0] xfer_cnt,
  input logic             dma_req,
  input logic             xfer_stb,
  input logic             word_irq,
  input logic             stat_active,
  input logic             stat_chain
);

  logic rsv_code;
  logic mast_idle;
  assign rsv_code  = cfg_ext & (~cfg_hshake | cfg_master);
  assign mast_idle = cfg_master & ~cfg_hshake & ~cfg_ext & (xfer_cnt == '0);

  // R7
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rsv_code) |-> (!dma_req && !xfer_stb));

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_en) |-> (!dma_req && !xfer_stb));

  // R5
  mast_zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mast_idle) |-> (!xfer_stb && !dma_req));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_irq_en) |-> !word_irq);

  // R12
  chain_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    stat_chain |-> $past(cfg_en, 2));

  // R13
  act_rise_lag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_active) |-> ($past(cfg_en, 2) && $past(xfer_cnt != '0, 2)));

endmodule

bind xp_dma_pacer pace_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_en      (cfg_en),
  .cfg_chain   (cfg_chain),
  .cfg_tx      (cfg_tx),
  .cfg_master  (cfg_master),
  .cfg_hshake  (cfg_hshake),
  .cfg_ext     (cfg_ext),
  .cfg_irq_en  (cfg_irq_en),
  .buf_empty   (buf_empty),
  .buf_full    (buf_full),
  .xfer_cnt    (xfer_cnt),
  .dma_req     (dma_req),
  .xfer_stb    (xfer_stb),
  .word_irq    (word_irq),
  .stat_active (stat_active),
  .stat_chain  (stat_chain)
);

// File: tb/xp_dma_pacer_tb.sv
`timescale 1ns/1ps
module xp_dma_pacer_tb;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 0, cfg_chain = 0, cfg_tx = 0;
  logic cfg_master = 0, cfg_hshake = 0, cfg_ext = 0, cfg_irq_en = 0;
  logic buf_empty = 1, buf_full = 0;
  logic [CNT_W-1:0] xfer_cnt = '0;
  logic ext_req = 0, ext_grant = 0, rd_stb = 0, wr_stb = 0;
  logic dma_req, xfer_stb, word_irq, stat_active, stat_chain;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit run = 0;

  always #2 clk = ~clk;

  xp_dma_pacer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_chain(cfg_chain), .cfg_tx(cfg_tx),
    .cfg_master(cfg_master), .cfg_hshake(cfg_hshake), .cfg_ext(cfg_ext),
    .cfg_irq_en(cfg_irq_en), .buf_empty(buf_empty), .buf_full(buf_full),
    .xfer_cnt(xfer_cnt), .ext_req(ext_req), .ext_grant(ext_grant),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .dma_req(dma_req), .xfer_stb(xfer_stb),
    .word_irq(word_irq), .stat_active(stat_active), .stat_chain(stat_chain)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  function automatic string mode_tag(input int code);
    case (code)
      0: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // reference model
  bit m_req, m_stb, m_irq, m_act_i, m_chn_i, m_act, m_chn;
  string t_req = "R1", t_stb = "R1";

  always @(posedge clk) begin
    int code;
    bit need, nz, r, s;
    if (rst) begin
      m_req = 0; m_stb = 0; m_irq = 0;
      m_act_i = 0; m_chn_i = 0; m_act = 0; m_chn = 0;
      t_req = "R1"; t_stb = "R1";
    end else begin
      code = cfg_master * 4 + cfg_hshake * 2 + cfg_ext;
      need = cfg_tx ? !buf_full : !buf_empty;
      nz = (xfer_cnt != 0);
      r = 0; s = 0;
      if (cfg_en) begin
        case (code)
          0: r = need;
          2, 3: begin r = cfg_tx ? need : ext_req; s = ext_grant; end
          4: begin r = need && nz; s = need && nz; end
          6: begin r = nz && (cfg_tx ? need : ext_req); s = nz && (cfg_tx ? wr_stb : rd_stb); end
          default: ;
        endcase
      end
      m_req = r; m_stb = s;
      m_irq = cfg_irq_en && need;
      t_stb = cfg_en ? mode_tag(code) : "R10";
      if (!cfg_en) t_req = "R10";
      else if (mode_tag(code) == "R7") t_req = "R7";
      else if (cfg_tx) t_req = "R8";
      else t_req = mode_tag(code);
      m_act = m_act_i;
      m_chn = m_chn_i;
      if (!cfg_en) m_act_i = 0;
      else if (nz) m_act_i = 1;
      else if (buf_empty) m_act_i = 0;
      m_chn_i = cfg_en && cfg_chain;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (run) begin
      check(dma_req, m_req, t_req, "dma_req");
      check(xfer_stb, m_stb, t_stb, "xfer_stb");
      check(word_irq, m_irq, "R9", "word_irq");
      check(stat_active, m_act, "R11", "stat_active");
      check(stat_chain, m_chn, "R12", "stat_chain");
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    logic [31:0] lf;
    lf = 32'h1bad_c0de;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(dma_req, 1'b0, "R1", "dma_req in reset");
    check(xfer_stb, 1'b0, "R1", "xfer_stb in reset");
    check(word_irq, 1'b0, "R1", "word_irq in reset");
    check(stat_active, 1'b0, "R1", "stat_active in reset");
    check(stat_chain, 1'b0, "R1", "stat_chain in reset");
    tick();
    rst = 0;
    run = 1;
    tick();
    // R13 latency: slave receive with data present
    cfg_en = 1; cfg_chain = 1; buf_empty = 0; xfer_cnt = 5;
    @(negedge clk);
    check(dma_req, 1'b0, "R13", "req before edge");
    @(negedge clk);
    check(dma_req, 1'b1, "R13", "req one edge later");
    check(stat_active, 1'b0, "R13", "status not yet");
    @(negedge clk);
    check(stat_active, 1'b1, "R13", "status two edges later");
    check(stat_chain, 1'b1, "R13", "chain two edges later");
    // R8 transmit prefill under handshake without ext_req
    tick();
    cfg_tx = 1; cfg_hshake = 1; buf_full = 0; buf_empty = 1; ext_req = 0;
    tick(); @(negedge clk);
    check(dma_req, 1'b1, "R8", "tx prefill without ext_req");
    // R12 chain insertion
    tick();
    cfg_en = 0; cfg_chain = 1;
    repeat (3) tick();
    @(negedge clk);
    check(stat_chain, 1'b0, "R12", "chain insertion");
    // R7 reserved with everything else asking
    tick();
    cfg_en = 1; cfg_master = 1; cfg_hshake = 0; cfg_ext = 1; ext_req = 1; ext_grant = 1;
    tick(); @(negedge clk);
    check(dma_req, 1'b0, "R7", "reserved 101 req");
    check(xfer_stb, 1'b0, "R7", "reserved 101 stb");
    // randomized sweep, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      tick();
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      cfg_en     = (lf[2:0] != 0);
      cfg_chain  = lf[3];
      cfg_tx     = lf[4];
      cfg_master = lf[5];
      cfg_hshake = lf[6];
      cfg_ext    = lf[7] & lf[8];
      cfg_irq_en = lf[9];
      buf_empty  = lf[10] & lf[11];
      buf_full   = ~buf_empty & lf[12] & lf[13];
      xfer_cnt   = (lf[15:14] == 0) ? '0 : CNT_W'(lf[23:16]);
      ext_req    = lf[24];
      ext_grant  = lf[25];
      rd_stb     = lf[26];
      wr_stb     = lf[27];
    end
    tick();
    @(negedge clk);
    run = 0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule